// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Front End

This block sits in front of a single-port word memory and lets read and write cycles alternate on every clock edge without idle cycles. Each rising edge registers a command (address, load/advance, read/write select, three chip selects and per-lane write enables) and classifies it as a deselect, a continued deselect, a started or continued read, a started or continued write, a stalled edge or a sleep edge. Reads are flow-through: the word appears on the output in the cycle after the edge that registered its address. Write data trails its address by one active edge. It is captured into a pending-write register and reaches the array on the following active edge.

A read that targets the address held in the pending-write register returns the enabled bytes of that register merged with the stored word, so data is always coherent. The output bus is modelled as a data vector plus a drive flag; the vector reads zero whenever the flag is low. On continue cycles the address input carries the next burst address from a separate sequencer. The sequence itself is not produced here.

Top module: `zt_sram_front`

## Requirements
- R1: A command is loaded only at an active edge with `ld_n` low. The block is selected only when `sel_n`=0, `sel2_n`=0 and `sel3`=1. A load with any other select combination is a deselect: `cycle_type`=0 and `q_oe`=0.
- R2: At an active edge with `ld_n` high, `rd_wr_n` and the selects are ignored and the type of the last load continues. `cycle_type` is 3 after a read, 5 after a write and 1 after a deselect. A read never turns into a write without a new load, and a write never turns into a read.
- R3: A load with `rd_wr_n`=1 gives `cycle_type`=2. After that edge, `q` shows the addressed word with `q_oe`=1 if `oe_n` is low. With `oe_n` high (a dummy read), `q_oe` stays 0.
- R4: A load with `rd_wr_n`=0 gives `cycle_type`=4. Write data is sampled on `wdata` at the next active edge. Lane i is bits [9i+8:9i] and is written only if `bwe_n[i]`=0. The enables are taken with the address. All enables high is an abort that leaves memory unchanged.
- R5: A read of the address whose write data is still pending returns the newly written lanes merged with the old contents of the other lanes.
- R6: `q_oe` is 0 during write, deselect and continued-deselect cycles, whatever `oe_n` is. `q` is all zeros whenever `q_oe` is 0.
- R7: An edge with `clk_en_n` high is ignored and gives `cycle_type`=6. No command is loaded, no write data is taken and memory is not written. A read in progress keeps driving the same data.
- R8: While `sleep` is high, and for two edges after it falls, edges are ignored and give `cycle_type`=7. `q_oe` goes to 0 as soon as `sleep` rises and stays 0 through that window. Memory contents are kept.
- R9: While `rst_n` is low, `q_oe` is 0 and `cycle_type` is 0.
- R10: Any mix of back-to-back reads, writes, partial writes and stalls returns, on every read, the word a reference array holds after all earlier writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high stalls the edge |
| sleep | input | 1 | Asynchronous active-high sleep request |
| ld_n | input | 1 | Low loads a new command, high advances the current one |
| rd_wr_n | input | 1 | 1 = read, 0 = write; sampled at load edges only |
| sel_n | input | 1 | Active-low chip select |
| sel2_n | input | 1 | Second active-low chip select |
| sel3 | input | 1 | Active-high chip select |
| bwe_n | input | LANES | Active-low write enable per 9-bit lane |
| addr | input | ADDR_W | Word address (loaded or next burst address) |
| wdata | input | LANES*LANE_W | Write data for the previous write command |
| oe_n | input | 1 | Active-low output enable |
| q | output | LANES*LANE_W | Read data; zero when not driven |
| q_oe | output | 1 | Bus drive flag |
| cycle_type | output | 3 | Kind of the most recent edge (codes in R1 to R8) |

## Verification
The two functions that meet in one cycle are the pending-write bypass and the stall or write commit. A write is followed at once by a read of the same address, so the read merges data that is still in flight. In another case a clock-enable stall lands between a write command and its data edge, with unrelated data offered on the stalled edge. Each read is compared with a reference array that the bench updates when it supplies write data. The same comparison runs over a long stretch of random loads, partial writes and stalls confined to four addresses, so bypass hits are frequent.

// File: rtl/zt_pkg.sv
package zt_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  typedef enum logic [2:0] {
    CY_DESEL      = 3'd0,
    CY_DESEL_CONT = 3'd1,
    CY_RD         = 3'd2,
    CY_RD_CONT    = 3'd3,
    CY_WR         = 3'd4,
    CY_WR_CONT    = 3'd5,
    CY_STALL      = 3'd6,
    CY_SLEEP      = 3'd7
  } cyc_e;

endpackage

// File: rtl/zt_cmd_ctl.sv
module zt_cmd_ctl
  import zt_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int LANES      = 2,
  parameter int WAKE_EDGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              sleep,
  input  logic              ld_n,
  input  logic              rd_wr_n,
  input  logic              sel_n,
  input  logic              sel2_n,
  input  logic              sel3,
  input  logic [LANES-1:0]  bwe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              go,
  output logic              quiet,
  output op_e               op,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LANES-1:0]  cur_bwe_n,
  output cyc_e              kind
);

  // sleep history: edges stay ignored until it has drained
  logic [WAKE_EDGES-1:0] wake_q;
  logic                  chosen;
  op_e                   op_d;
  cyc_e                  kind_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= '0;
    else        wake_q <= (wake_q << 1) | WAKE_EDGES'(sleep);
  end

  assign quiet  = sleep | (|wake_q);
  assign go     = !clk_en_n && !quiet;
  assign chosen = !sel_n && !sel2_n && sel3;

  always_comb begin
    op_d = op;
    if (!ld_n) begin
      if (!chosen)      op_d = OP_IDLE;
      else if (rd_wr_n) op_d = OP_READ;
      else              op_d = OP_WRITE;
    end
  end

  always_comb begin
    if (quiet)         kind_d = CY_SLEEP;
    else if (clk_en_n) kind_d = CY_STALL;
    else if (!ld_n) begin
      case (op_d)
        OP_READ:  kind_d = CY_RD;
        OP_WRITE: kind_d = CY_WR;
        default:  kind_d = CY_DESEL;
      endcase
    end else begin
      case (op)
        OP_READ:  kind_d = CY_RD_CONT;
        OP_WRITE: kind_d = CY_WR_CONT;
        default:  kind_d = CY_DESEL_CONT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op        <= OP_IDLE;
      cur_addr  <= '0;
      cur_bwe_n <= '1;
      kind      <= CY_DESEL;
    end else begin
      kind <= kind_d;
      if (go) begin
        op        <= op_d;
        cur_addr  <= addr;
        cur_bwe_n <= bwe_n;
      end
    end
  end

endmodule

// File: rtl/zt_wr_pipe.sv
module zt_wr_pipe
  import zt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    go,
  input  op_e                     cur_op,
  input  logic [ADDR_W-1:0]       cur_addr,
  input  logic [LANES-1:0]        cur_bwe_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES*LANE_W-1:0] mem_word,
  output logic                    commit_en,
  output logic [ADDR_W-1:0]       commit_addr,
  output logic [LANES-1:0]        commit_bwe_n,
  output logic [LANES*LANE_W-1:0] commit_data,
  output logic [LANES*LANE_W-1:0] rd_word
);

  logic                    pend_v;
  logic [ADDR_W-1:0]       pend_a;
  logic [LANES-1:0]        pend_b;
  logic [LANES*LANE_W-1:0] pend_d;
  logic                    hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v <= 1'b0;
      pend_a <= '0;
      pend_b <= '1;
      pend_d <= '0;
    end else if (go) begin
      pend_v <= (cur_op == OP_WRITE) && !(&cur_bwe_n);
      if (cur_op == OP_WRITE) begin
        pend_a <= cur_addr;
        pend_b <= cur_bwe_n;
        pend_d <= wdata;
      end
    end
  end

  assign commit_en    = go && pend_v;
  assign commit_addr  = pend_a;
  assign commit_bwe_n = pend_b;
  assign commit_data  = pend_d;
  assign hit          = pend_v && (pend_a == cur_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign rd_word[g*LANE_W +: LANE_W] = (hit && !pend_b[g]) ?
                                         pend_d[g*LANE_W +: LANE_W] :
                                         mem_word[g*LANE_W +: LANE_W];
  end

endmodule

// File: rtl/zt_store.sv
module zt_store #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES-1:0]        wbe_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (we && !wbe_n[g]) cells[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
  end

endmodule

// File: rtl/zt_sram_front.sv
module zt_sram_front
  import zt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en_n,
  input  logic                    sleep,
  input  logic                    ld_n,
  input  logic                    rd_wr_n,
  input  logic                    sel_n,
  input  logic                    sel2_n,
  input  logic                    sel3,
  input  logic [LANES-1:0]        bwe_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe_n,
  output logic [LANES*LANE_W-1:0] q,
  output logic                    q_oe,
  output logic [2:0]              cycle_type
);

  localparam int DW = LANES * LANE_W;

  logic              go;
  logic              quiet;
  op_e               op;
  logic [ADDR_W-1:0] cur_addr;
  logic [LANES-1:0]  cur_bwe_n;
  cyc_e              kind;
  logic              commit_en;
  logic [ADDR_W-1:0] commit_addr;
  logic [LANES-1:0]  commit_bwe_n;
  logic [DW-1:0]     commit_data;
  logic [DW-1:0]     mem_word;
  logic [DW-1:0]     rd_word;

  zt_cmd_ctl #(.ADDR_W(ADDR_W), .LANES(LANES), .WAKE_EDGES(2)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en_n  (clk_en_n),
    .sleep     (sleep),
    .ld_n      (ld_n),
    .rd_wr_n   (rd_wr_n),
    .sel_n     (sel_n),
    .sel2_n    (sel2_n),
    .sel3      (sel3),
    .bwe_n     (bwe_n),
    .addr      (addr),
    .go        (go),
    .quiet     (quiet),
    .op        (op),
    .cur_addr  (cur_addr),
    .cur_bwe_n (cur_bwe_n),
    .kind      (kind)
  );

  zt_wr_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wp (
    .clk          (clk),
    .rst_n        (rst_n),
    .go           (go),
    .cur_op       (op),
    .cur_addr     (cur_addr),
    .cur_bwe_n    (cur_bwe_n),
    .wdata        (wdata),
    .mem_word     (mem_word),
    .commit_en    (commit_en),
    .commit_addr  (commit_addr),
    .commit_bwe_n (commit_bwe_n),
    .commit_data  (commit_data),
    .rd_word      (rd_word)
  );

  zt_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk   (clk),
    .we    (commit_en),
    .waddr (commit_addr),
    .wbe_n (commit_bwe_n),
    .wdata (commit_data),
    .raddr (cur_addr),
    .rdata (mem_word)
  );

  assign q_oe       = (op == OP_READ) && !oe_n && !quiet;
  assign q          = q_oe ? rd_word : '0;
  assign cycle_type = kind;

endmodule

// File: rtl/zt_sram_front_chk.sv
module zt_sram_front_chk
  import zt_pkg::*;
#(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en_n,
  input logic          sleep,
  input logic          ld_n,
  input logic          sel_n,
  input logic          sel2_n,
  input logic          sel3,
  input logic          oe_n,
  input logic [DW-1:0] q,
  input logic          q_oe,
  input logic [2:0]    cycle_type
);

  logic live;
  assign live = !clk_en_n && !sleep && (cycle_type != CY_SLEEP);

  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_n |-> (!q_oe && cycle_type == CY_DESEL));

  p_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_type == CY_WR || cycle_type == CY_WR_CONT ||
     cycle_type == CY_DESEL || cycle_type == CY_DESEL_CONT) |-> (!q_oe && q == '0));

  p_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !ld_n && !(!sel_n && !sel2_n && sel3)) |=> (cycle_type == CY_DESEL && !q_oe));

  p_cont_desel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (live && ld_n && (cycle_type == CY_DESEL || cycle_type == CY_DESEL_CONT))
    |=> (cycle_type == CY_DESEL_CONT));

  p_read_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (live && ld_n && (cycle_type == CY_RD || cycle_type == CY_RD_CONT))
    |=> (cycle_type == CY_RD_CONT));

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en_n && !sleep && cycle_type != CY_SLEEP)
    |=> (cycle_type == CY_STALL && (sleep || !$stable(oe_n) || $stable(q))));

  p_sleep_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !q_oe);

  p_sleep_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (cycle_type == CY_SLEEP && !q_oe));

endmodule

bind zt_sram_front zt_sram_front_chk #(.DW(LANES*LANE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clk_en_n   (clk_en_n),
  .sleep      (sleep),
  .ld_n       (ld_n),
  .sel_n      (sel_n),
  .sel2_n     (sel2_n),
  .sel3       (sel3),
  .oe_n       (oe_n),
  .q          (q),
  .q_oe       (q_oe),
  .cycle_type (cycle_type)
);

// File: tb/zt_sram_front_bench.sv
module zt_sram_front_bench;

  localparam int AW    = 6;
  localparam int NL    = 2;
  localparam int LW    = 9;
  localparam int DW    = NL * LW;
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] ON  = 3'b001;
  localparam logic [2:0] OFF = 3'b101;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_en_n = 1'b0;
  logic          sleep = 1'b0;
  logic          ld_n = 1'b0;
  logic          rd_wr_n = 1'b1;
  logic          sel_n = 1'b1;
  logic          sel2_n = 1'b0;
  logic          sel3 = 1'b1;
  logic [NL-1:0] bwe_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          oe_n = 1'b0;
  logic [DW-1:0] q;
  logic          q_oe;
  logic [2:0]    cycle_type;

  always #2 clk = ~clk;

  zt_sram_front #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_zt_sram_front (
    .clk (clk), .rst_n (rst_n), .clk_en_n (clk_en_n), .sleep (sleep),
    .ld_n (ld_n), .rd_wr_n (rd_wr_n), .sel_n (sel_n), .sel2_n (sel2_n),
    .sel3 (sel3), .bwe_n (bwe_n), .addr (addr), .wdata (wdata),
    .oe_n (oe_n), .q (q), .q_oe (q_oe), .cycle_type (cycle_type)
  );

  int total = 0;
  int bad   = 0;

  // reference model
  logic [DW-1:0] ref_mem [DEPTH];
  int            b_op = 0;
  bit            pv = 0;
  logic [AW-1:0] pa = '0;
  logic [AW-1:0] b_addr = '0;
  logic [NL-1:0] pb = '1;
  int            wake = 0;

  task automatic check(input string tag, input logic [DW+3:0] got, input logic [DW+3:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got oe=%0b type=%0d q=%h, expected oe=%0b type=%0d q=%h",
               tag, got[DW+3], got[DW+2:DW], got[DW-1:0], exp[DW+3], exp[DW+2:DW], exp[DW-1:0]);
    end
  endtask

  task automatic drv(input logic l, input logic rw, input logic [2:0] s, input logic [NL-1:0] bw,
                     input logic [AW-1:0] a, input logic [DW-1:0] d, input logic cen, input logic oe);
    ld_n = l; rd_wr_n = rw; {sel_n, sel2_n, sel3} = s; bwe_n = bw;
    addr = a; wdata = d; clk_en_n = cen; oe_n = oe;
  endtask

  task automatic tick(input string tag);
    bit            ign;
    bit            eoe;
    logic [2:0]    ety;
    logic [DW-1:0] eq;
    ign = sleep || (wake > 0);
    if (ign) ety = 3'd7;
    else if (clk_en_n) ety = 3'd6;
    else begin
      if (pv) for (int l = 0; l < NL; l++) if (!pb[l]) ref_mem[pa][l*LW +: LW] = wdata[l*LW +: LW];
      if (!ld_n) begin
        if (!sel_n && !sel2_n && sel3) begin
          b_op = rd_wr_n ? 1 : 2;
          ety  = rd_wr_n ? 3'd2 : 3'd4;
        end else begin
          b_op = 0; ety = 3'd0;
        end
      end else ety = (b_op == 0) ? 3'd1 : (b_op == 1) ? 3'd3 : 3'd5;
      pv = (b_op == 2) && (bwe_n != '1);
      pa = addr; pb = bwe_n; b_addr = addr;
    end
    if (sleep) wake = 2;
    else if (wake > 0) wake--;
    @(posedge clk);
    #1;
    eoe = (b_op == 1) && !oe_n && !sleep && (wake == 0);
    eq  = eoe ? ref_mem[b_addr] : '0;
    check(tag, {q_oe, cycle_type, q}, {eoe, ety, eq});
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 1031 + 7);
  endfunction

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset", {q_oe, cycle_type, q}, {1'b0, 3'd0, {DW{1'b0}}});
    rst_n = 1'b1;
  endtask

  task automatic t_fill();
    for (int a = 0; a < DEPTH; a++) begin
      drv(0, 0, ON, '0, AW'(a), (a == 0) ? '0 : pat(a - 1), 0, 0);
      tick("R4 fill");
    end
    drv(0, 1, OFF, '1, '0, pat(DEPTH - 1), 0, 0);
    tick("R1 deselect after fill");
  endtask

  task automatic t_select();
    for (int s = 0; s < 8; s++) begin
      drv(0, 1, 3'(s), '1, AW'(s + 10), '0, 0, 0);
      tick("R1 select combination");
    end
  endtask

  task automatic t_alternate();
    drv(0, 0, ON, 2'b00, 1, '0, 0, 0);         tick("R10 write a1");
    drv(0, 1, ON, 2'b11, 1, 18'h12345, 0, 0);  tick("R5 read pending a1");
    drv(0, 0, ON, 2'b00, 2, '0, 0, 0);         tick("R6 write a2");
    drv(0, 1, ON, 2'b11, 3, 18'h0ABCD, 0, 0);  tick("R10 read a3");
    drv(0, 0, ON, 2'b01, 1, '0, 0, 0);         tick("R4 lane1 write a1");
    drv(0, 1, ON, 2'b11, 1, 18'h3FFFF, 0, 0);  tick("R5 merged read a1");
    drv(0, 1, ON, 2'b11, 2, '0, 0, 0);         tick("R10 read a2");
    drv(0, 1, OFF, 2'b11, 0, '0, 0, 0);        tick("R1 deselect");
  endtask

  task automatic t_bytes();
    drv(0, 0, ON, 2'b10, 5, '0, 0, 0);         tick("R4 lane0 write a5");
    drv(0, 1, ON, 2'b11, 5, 18'h2AAAA, 0, 0);  tick("R5 lane0 merge a5");
    drv(0, 0, ON, 2'b11, 5, '0, 0, 0);         tick("R4 abort a5");
    drv(0, 1, ON, 2'b11, 5, 18'h15555, 0, 0);  tick("R4 abort unchanged a5");
    drv(0, 1, ON, 2'b11, 5, '0, 0, 0);         tick("R4 abort stays unchanged");
  endtask

  task automatic t_burst();
    drv(0, 0, ON, 2'b00, 8, '0, 0, 0);         tick("R4 burst write load");
    drv(1, 1, OFF, 2'b00, 9, 18'h00111, 0, 0); tick("R2 write continues");
    drv(1, 1, OFF, 2'b00, 10, 18'h00222, 0, 0); tick("R2 write continues");
    drv(0, 1, ON, 2'b11, 8, 18'h00333, 0, 0);  tick("R3 burst read load");
    drv(1, 0, OFF, 2'b00, 9, 18'h3F0F0, 0, 0); tick("R2 read continues");
    drv(1, 0, OFF, 2'b00, 10, '0, 0, 0);       tick("R2 read continues");
    drv(0, 1, OFF, 2'b11, 0, '0, 0, 0);        tick("R1 deselect");
    drv(1, 0, ON, 2'b00, 11, '0, 0, 0);        tick("R2 continue deselect");
    drv(1, 1, ON, 2'b00, 12, '0, 0, 0);        tick("R2 continue deselect");
  endtask

  task automatic t_dummy();
    drv(0, 1, ON, 2'b11, 8, '0, 0, 1);         tick("R3 dummy read");
    drv(0, 1, ON, 2'b11, 8, '0, 0, 0);         tick("R3 driven read");
    drv(0, 0, ON, 2'b00, 20, '0, 0, 0);        tick("R6 write ignores oe");
    drv(0, 1, OFF, 2'b11, 0, 18'h1C3C3, 0, 0); tick("R6 deselect");
  endtask

  task automatic t_stall();
    drv(0, 1, ON, 2'b11, 20, '0, 0, 0);        tick("R3 read before stall");
    drv(0, 0, ON, 2'b00, 33, 18'h3FFFF, 1, 0); tick("R7 stall keeps read");
    drv(0, 0, ON, 2'b00, 21, '0, 0, 0);        tick("R10 write a21");
    drv(0, 1, ON, 2'b11, 40, 18'h3DEAD, 1, 0); tick("R7 stall on data edge");
    drv(0, 1, ON, 2'b11, 21, 18'h0BEEF, 0, 0); tick("R7 data after stall");
    drv(0, 1, ON, 2'b11, 40, '0, 0, 0);        tick("R7 a40 untouched");
  endtask

  task automatic t_sleep();
    drv(0, 0, ON, 2'b00, 30, '0, 0, 0);        tick("R10 write a30");
    drv(0, 1, ON, 2'b11, 30, 18'h2468A, 0, 0); tick("R5 read a30");
    sleep = 1'b1;
    #1;
    check("R8 sleep output off", {q_oe, q}, {1'b0, {DW{1'b0}}});
    drv(0, 0, ON, 2'b00, 30, '0, 0, 0);        tick("R8 sleep ignores write");
    drv(0, 0, ON, 2'b00, 30, 18'h11111, 0, 0); tick("R8 sleep ignores data");
    drv(0, 1, ON, 2'b11, 30, '0, 0, 0);        tick("R8 sleep ignores read");
    sleep = 1'b0;
    tick("R8 wake edge 1");
    drv(0, 0, ON, 2'b00, 30, 18'h22222, 0, 0); tick("R8 wake edge 2");
    drv(0, 1, ON, 2'b11, 30, 18'h33333, 0, 0); tick("R8 retained a30");
    drv(0, 1, ON, 2'b11, 1, '0, 0, 0);         tick("R8 retained a1");
  endtask

  task automatic t_random();
    for (int i = 0; i < 400; i++) begin
      int unsigned r = $urandom;
      logic cen = (r[2:0] == 3'd0);
      logic l   = (r[5:3] == 3'd0);
      drv(l, r[6], ON, r[8:7], AW'(r[10:9]), DW'($urandom), cen, r[11] & r[12]);
      tick("R10 random mix");
    end
    drv(0, 1, OFF, '1, '0, DW'($urandom), 0, 0);
    tick("R10 random tail");
  endtask

  initial begin
    #(4 * 20000);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    t_reset();
    @(posedge clk);
    #1;
    t_fill();
    t_select();
    t_alternate();
    t_bytes();
    t_burst();
    t_dummy();
    t_stall();
    t_sleep();
    t_random();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule